// File: doc/BRIEF.md
# Burst Serial Clock Generator with Hold

This block emits a gated serial clock for a set number of counted periods and presents one data word per counted period. It suits the transmit clocking side of a serial master. A free-running system clock drives it. The output clock is a registered signal that a phase counter toggles, so the system clock itself is never gated. The length of a burst is the sum of several length fields, which are latched when the burst starts.

A hold input is sampled at the start of every output-clock period. A held period still toggles the serial clock. It does not count toward the burst length and does not advance the data source. During a held period the data bus carries pseudo-random filler and the valid flag is low. Once hold is released, the block issues exactly the number of counted periods that were still owed. When enable drops, the block completes the current period and then abandons the burst. A burst whose length sums to zero finishes at once, without any clock pulses.

Top module: `burst_sclk_gen`

## Requirements
- R1: The burst length is the sum of the FIELDS unsigned FIELD_W-bit slices of `len_fields` (slice i at bits i*FIELD_W upward), captured on the cycle `start` is accepted. Later changes to `len_fields` do not alter the running burst.
- R2: Every output clock period is 2*HALF_DIV system cycles long, with HALF_DIV cycles high followed by HALF_DIV cycles low.
- R3: `src_adv` pulses for one cycle at the start of each counted period. The word on `src_data` in that cycle appears on `dout` with `dout_valid` high from the rising edge of `sclk` until the next period begins.
- R4: Hold is sampled in the cycle before each rising edge of `sclk`. A held period still toggles `sclk`, keeps the remaining count unchanged, drives `dout_valid` low with filler on `dout`, and raises no `src_adv`.
- R5: The number of counted periods in a burst equals the captured length, however long or often hold is asserted.
- R6: While no burst runs, `busy`, `sclk` and `dout_valid` are low, including after reset.
- R7: Dropping `enable` during a burst ends it after the current period. No `done` pulse is raised, the remaining count is cleared, and a later burst runs its full length.
- R8: `done` is a one-cycle pulse raised in the first cycle after the final counted period ends, and `busy` is low in that cycle.
- R9: A start whose length sums to zero raises `done` in the next cycle, with no `sclk` pulse and `busy` staying low.
- R10: `start` has no effect while a burst is running or while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Level that allows a burst to start and keep running |
| start | input | 1 | Request to begin a burst |
| len_fields | input | FIELDS*FIELD_W | Packed length fields that are summed into the burst length |
| hold | input | 1 | Freezes counting for the sampled period |
| src_data | input | DATA_W | Next word offered by the data source |
| src_adv | output | 1 | Advance strobe to the data source |
| sclk | output | 1 | Generated serial clock |
| dout | output | DATA_W | Word (or filler) for the current period |
| dout_valid | output | 1 | High when `dout` carries a source word |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse on burst completion |

## Verification
A corrupted remaining count shows up at the ports within a single burst: the number of valid words differs from the captured length, or the scoreboard queue underflows or is left non-empty. A broken phase counter appears in the first period as a high or low phase of the wrong length. A hold that leaks into the count, or that advances the source, shows up as a missing word, or as `dout` holding the wrong word at the very next counted rising edge.

// File: rtl/burst_sclk_gen.sv
module burst_sclk_gen #(
  parameter int DATA_W   = 16,
  parameter int FIELDS   = 3,
  parameter int FIELD_W  = 8,
  parameter int HALF_DIV = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      start,
  input  logic [FIELDS*FIELD_W-1:0] len_fields,
  input  logic                      hold,
  input  logic [DATA_W-1:0]         src_data,
  output logic                      src_adv,
  output logic                      sclk,
  output logic [DATA_W-1:0]         dout,
  output logic                      dout_valid,
  output logic                      busy,
  output logic                      done
);
  localparam int LEN_W = FIELD_W + $clog2(FIELDS + 1);
  localparam int PER   = 2 * HALF_DIV;
  localparam int PH_W  = (PER > 2) ? $clog2(PER) : 1;
  localparam int REP   = (DATA_W + 15) / 16;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(HALF_DIV - 1);

  logic [LEN_W-1:0]    len_sum;
  logic [LEN_W-1:0]    rem;
  logic [PH_W-1:0]     ph;
  logic [15:0]         lfsr;
  logic [REP*16-1:0]   fill_rep;
  logic [DATA_W-1:0]   fill;

  always_comb begin
    len_sum = '0;
    for (int i = 0; i < FIELDS; i++)
      len_sum = len_sum + LEN_W'(len_fields[i*FIELD_W +: FIELD_W]);
  end

  assign fill_rep = {REP{lfsr}};
  assign fill     = fill_rep[DATA_W-1:0];

  wire launch   = !busy && start && enable && (len_sum != '0);
  wire zero_req = !busy && start && enable && (len_sum == '0);
  wire wrap     = busy && (ph == PH_LAST);
  wire cont     = wrap && enable && (rem != '0);
  wire ps       = launch || cont;

  assign src_adv = ps && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sclk       <= 1'b0;
      ph         <= '0;
      rem        <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= zero_req;
      if (ps) begin
        busy       <= 1'b1;
        sclk       <= 1'b1;
        ph         <= '0;
        rem        <= (launch ? len_sum : rem) - LEN_W'(!hold);
        dout_valid <= !hold;
        dout       <= hold ? fill : src_data;
      end else if (wrap) begin
        busy       <= 1'b0;
        ph         <= '0;
        rem        <= '0;
        dout_valid <= 1'b0;
        done       <= (rem == '0);
      end else if (busy) begin
        ph <= ph + 1'b1;
        if (ph == PH_FALL) sclk <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !dout_valid)) else $error("idle outputs active"); // R6

  AST_ADV_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    src_adv |=> (dout_valid && dout == $past(src_data))) else $error("word not presented"); // R3

  AST_HELD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && hold) |=> (rem == $past(rem) && !dout_valid)) else $error("held period counted"); // R4

  AST_RISE_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (busy && ph == '0)) else $error("stray rising edge"); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R8

  AST_NO_ADV_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !busy) else $error("burst without enable"); // R10
endmodule

// File: tb/burst_sclk_gen_tb.sv
module burst_sclk_gen_tb_top;
  localparam int DATA_W = 16, FIELDS = 3, FIELD_W = 8, HALF_DIV = 5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0, hold = 1'b0;
  logic [FIELDS*FIELD_W-1:0] len_fields = '0;
  logic [DATA_W-1:0] src_data;
  logic src_adv, sclk, dout_valid, busy, done;
  logic [DATA_W-1:0] dout;

  always #10 clk = ~clk;

  burst_sclk_gen #(.DATA_W(DATA_W), .FIELDS(FIELDS), .FIELD_W(FIELD_W), .HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .len_fields(len_fields),
    .hold(hold), .src_data(src_data), .src_adv(src_adv), .sclk(sclk), .dout(dout),
    .dout_valid(dout_valid), .busy(busy), .done(done));

  int src_idx = 0;
  assign src_data = DATA_W'(16'h1000 + src_idx);
  always @(posedge clk) if (src_adv) src_idx <= src_idx + 1;

  int tests = 0, fails = 0;
  logic [DATA_W-1:0] exp_q[$];
  int n_cnt = 0, n_held = 0, n_adv = 0, n_done = 0, n_rise = 0;
  logic sclk_prev = 1'b0;
  int hi_run = 0, lo_run = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (src_adv) n_adv++;
      if (done) n_done++;
      if (sclk && !sclk_prev) begin
        n_rise++;
        if (busy && lo_run != 0) check(lo_run == HALF_DIV, "R2 low phase", lo_run, HALF_DIV);
        hi_run = 1; lo_run = 0;
        if (dout_valid) begin
          n_cnt++;
          if (exp_q.size() == 0) check(0, "R5 extra counted period", n_cnt, 0);
          else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            check(dout == e, "R3 word", dout, e);
          end
        end else n_held++;
      end else if (sclk) hi_run++;
      else if (!sclk && sclk_prev) begin
        check(hi_run == HALF_DIV, "R2 high phase", hi_run, HALF_DIV);
        lo_run = 1;
      end else if (busy) lo_run++;
      else lo_run = 0;
      sclk_prev = sclk;
    end
  end

  function automatic logic [FIELDS*FIELD_W-1:0] pack(input int a, input int b, input int c);
    return {FIELD_W'(c), FIELD_W'(b), FIELD_W'(a)};
  endfunction

  task automatic clear_counts();
    n_cnt = 0; n_held = 0; n_adv = 0; n_done = 0; n_rise = 0;
  endtask

  task automatic start_burst(input int a, input int b, input int c);
    @(negedge clk);
    len_fields = pack(a, b, c);
    enable = 1'b1;
    start = 1'b1;
    for (int i = 0; i < a + b + c; i++) exp_q.push_back(DATA_W'(16'h1000 + src_idx + i));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_counted(input int n);
    for (int i = 0; i < 5000 && n_cnt < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !sclk && !dout_valid && !done, "R6 reset state", {busy, sclk, dout_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R5 R8: plain burst of 1+2+3
    clear_counts();
    start_burst(1, 2, 3);
    check(busy, "R1 busy after start", busy, 1);
    wait_idle();
    check(n_cnt == 6, "R1 R5 counted periods", n_cnt, 6);
    check(n_held == 0, "R4 no held periods", n_held, 0);
    check(n_adv == 6, "R3 advance count", n_adv, 6);
    check(n_done == 1, "R8 done pulses", n_done, 1);
    check(exp_q.size() == 0, "R5 words left", exp_q.size(), 0);
    check(!sclk && !dout_valid, "R6 idle after burst", sclk, 0);

    // R4 R5: hold after 5 of 10
    clear_counts();
    start_burst(3, 4, 3);
    wait_counted(5);
    hold = 1'b1;
    repeat (25) @(negedge clk);
    check(n_cnt == 5, "R4 count frozen during hold", n_cnt, 5);
    check(n_adv == 5, "R4 no advance during hold", n_adv, 5);
    check(n_held >= 1, "R4 clock keeps toggling", n_held, 1);
    hold = 1'b0;
    wait_idle();
    check(n_cnt == 10, "R5 counted after hold", n_cnt, 10);
    check(n_rise == n_cnt + n_held, "R4 rises total", n_rise, n_cnt + n_held);
    check(n_done == 1, "R8 done after hold burst", n_done, 1);

    // R4: hold already set at start
    clear_counts();
    hold = 1'b1;
    start_burst(2, 0, 0);
    repeat (30) @(negedge clk);
    check(n_cnt == 0 && n_held >= 2, "R4 held from start", n_held, 2);
    hold = 1'b0;
    wait_idle();
    check(n_cnt == 2, "R5 counted after initial hold", n_cnt, 2);

    // R1: fields change mid-burst
    clear_counts();
    start_burst(1, 1, 2);
    len_fields = pack(50, 50, 50);
    wait_idle();
    check(n_cnt == 4, "R1 length latched", n_cnt, 4);

    // R10: start while busy
    clear_counts();
    start_burst(3, 0, 0);
    repeat (7) @(negedge clk);
    len_fields = pack(9, 9, 9);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(n_cnt == 3 && n_done == 1, "R10 start ignored while busy", n_cnt, 3);

    // R10: start with enable low
    clear_counts();
    @(negedge clk);
    enable = 1'b0;
    len_fields = pack(2, 2, 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy && n_rise == 0 && n_done == 0, "R10 start without enable", n_rise, 0);

    // R7: abort then fresh burst
    clear_counts();
    start_burst(4, 4, 0);
    wait_counted(3);
    enable = 1'b0;
    wait_idle();
    check(n_cnt == 3, "R7 aborted count", n_cnt, 3);
    check(n_done == 0, "R7 no done on abort", n_done, 0);
    check(!sclk && !busy, "R7 idle after abort", sclk, 0);
    exp_q.delete();
    clear_counts();
    start_burst(2, 0, 0);
    wait_idle();
    check(n_cnt == 2 && n_done == 1, "R7 next burst full length", n_cnt, 2);

    // R9: zero length
    clear_counts();
    @(negedge clk);
    len_fields = '0;
    enable = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !busy, "R9 immediate done", done, 1);
    repeat (15) @(negedge clk);
    check(n_rise == 0 && n_done == 1, "R9 no clock pulses", n_rise, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule